// File: doc/BRIEF.md
# Timer Count Source Selector

This block decides when a timer counter advances. Each clock cycle it may raise a one-cycle count strobe. The strobe comes from one of four kinds of source:

- a free-running prescaler that divides the operation clock by 1, 2, 4, 8 or 32;
- an external input pin, which is synchronized and then edge-qualified;
- a strobe that a separate high-speed oscillator delivers already aligned to the operation clock;
- nothing, when the configuration is illegal. In that case a configuration-error flag is raised instead.

A 3-bit select code, an external-clock enable bit, a 2-bit edge field and a PWM3-mode flag together choose the source. The block sits directly in front of a timer counter.

The external path holds a synchronizer. An edge tracker follows it as a small state machine with three states:

- `ST_FILL`: entered at reset. It lasts until the synchronizer holds a real pin sample.
- `ST_LOW` and `ST_HIGH`: the settled level of the pin.

The transitions are:

- `ST_FILL` to `ST_LOW` or `ST_HIGH`: the fill is done. The state takes the synchronized level and emits no strobe.
- `ST_LOW` to `ST_HIGH`: a rise. A rise strobe is emitted.
- `ST_HIGH` to `ST_LOW`: a fall. A fall strobe is emitted.
- `ST_LOW` to `ST_LOW` and `ST_HIGH` to `ST_HIGH`: the level holds.

Top module: `cnt_src_sel`

## Requirements
- R1: Select codes 001, 010, 011 and 100 emit exactly one count strobe every 2, 4, 8 and 32 cycles respectively. After reset release with code 001, the strobe is 0 in the first cycle and 1 in the second.
- R2: Select code 000 emits a count strobe in every cycle.
- R3: Select code 101 with the enable bit at 1 and PWM3 mode at 0 counts edges of the external pin. The edge field selects which edges: 00 rising, 01 falling, 10 both, and 11 is treated as rising.
- R4: Select code 101 with the enable bit at 0 emits no strobe and raises the configuration-error flag.
- R5: Select code 101 in PWM3 mode emits no strobe and raises the configuration-error flag. Prescaler codes keep counting in PWM3 mode with the flag low.
- R6: Select code 111 emits no strobe and raises the configuration-error flag.
- R7: Select code 110 passes each oscillator strobe through as one count strobe while the oscillator enable is 1. While the enable is 0 it passes nothing and keeps the error flag low.
- R8: External high and low phases of 3 cycles each are all counted.
- R9: During reset the count strobe is 0. A pin held high through reset produces no strobe after release, for both rising and falling selection, until the pin really changes.
- R10: A pin change first seen at rising edge k appears on the count strobe after rising edge k+2, for exactly one cycle.
- R11: The configuration-error flag is 0 for every legal configuration. It follows the select inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Operation clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 3 | Source select code |
| ext_en_i | input | 1 | External-clock enable |
| edge_sel_i | input | 2 | External active-edge select |
| pwm3_mode_i | input | 1 | Timer is in PWM3 mode |
| ext_pin_i | input | 1 | Asynchronous external clock pin |
| osc_en_i | input | 1 | High-speed oscillator is running |
| osc_tick_i | input | 1 | Oscillator strobe, synchronous to clk_i |
| count_tick_o | output | 1 | One-cycle count-enable strobe |
| cfg_err_o | output | 1 | Illegal source configuration |

## Verification
The hardest situation to reach is the moment right after reset, when the pin has been high all along. A naive edge detector that starts from a zero history would report a false rising edge there. The bench holds the pin high across reset with rising selection and confirms that nothing is counted. It then repeats this with falling selection and confirms that exactly one strobe follows the first real drop. The table tests keep the pin and the oscillator toggling in the background, so that every suppressed configuration is tested against live activity rather than against quiet inputs.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef enum logic [2:0] {
        SEL_DIV1   = 3'b000,
        SEL_DIV2   = 3'b001,
        SEL_DIV4   = 3'b010,
        SEL_DIV8   = 3'b011,
        SEL_DIV32  = 3'b100,
        SEL_EXTPIN = 3'b101,
        SEL_HSOSC  = 3'b110,
        SEL_RSVD   = 3'b111
    } src_sel_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ST_FILL = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b10
    } edge_st_e;

endpackage

// File: rtl/cs_prescaler.sv
module cs_prescaler #(
    parameter int PRE_W = 5
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    output logic [PRE_W:0] tick_o
);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_q + 1'b1;
    end

    // Tap k: divide by 2**k, high when the low k bits are all ones.
    assign tick_o[0] = 1'b1;
    for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
        assign tick_o[k] = &cnt_q[k-1:0];
    end

    p_cnt_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == {PRE_W{1'b1}}) |=> (cnt_q == '0));

endmodule

// File: rtl/cs_ext_edge.sv
module cs_ext_edge
    import cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int FILL_W = $clog2(SYNC_STAGES + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(SYNC_STAGES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic [FILL_W-1:0]      fill_q;
    edge_st_e               st_q, st_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  fill_q <= '0;
        else if (st_q == ST_FILL && fill_q != FILL_LAST) fill_q <= fill_q + 1'b1;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_FILL;
        else         st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FILL: if (fill_q == FILL_LAST) st_d = lvl ? ST_HIGH : ST_LOW;
            ST_LOW:  if (lvl)  st_d = ST_HIGH;
            ST_HIGH: if (!lvl) st_d = ST_LOW;
            default: st_d = ST_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (st_q)
            ST_FILL: ;
            ST_LOW:  rise_o = lvl;
            ST_HIGH: fall_o = !lvl;
            default: ;
        endcase
    end

    p_rise_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (lvl && !$past(lvl)));
    p_fall_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> (!lvl && $past(lvl)));

endmodule

// File: rtl/cnt_src_sel.sv
module cnt_src_sel
    import cs_pkg::*;
#(
    parameter int DIV_MAX_LOG = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] src_sel_i,
    input  logic       ext_en_i,
    input  logic [1:0] edge_sel_i,
    input  logic       pwm3_mode_i,
    input  logic       ext_pin_i,
    input  logic       osc_en_i,
    input  logic       osc_tick_i,
    output logic       count_tick_o,
    output logic       cfg_err_o
);

    localparam int PRE_W = DIV_MAX_LOG;

    logic [PRE_W:0] pre_tick;
    logic           ext_rise, ext_fall, ext_strobe;
    logic           pick;
    logic           err;
    logic           tick_q;
    src_sel_e       sel;
    edge_sel_e      edg;

    cs_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(pre_tick)
    );

    cs_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (ext_pin_i),
        .rise_o(ext_rise),
        .fall_o(ext_fall)
    );

    assign sel = src_sel_e'(src_sel_i);
    assign edg = edge_sel_e'(edge_sel_i);

    always_comb begin
        unique case (edg)
            EDGE_RISE: ext_strobe = ext_rise;
            EDGE_FALL: ext_strobe = ext_fall;
            EDGE_BOTH: ext_strobe = ext_rise | ext_fall;
            EDGE_RSVD: ext_strobe = ext_rise;
            default:   ext_strobe = 1'b0;
        endcase
    end

    always_comb begin
        pick = 1'b0;
        err  = 1'b0;
        unique case (sel)
            SEL_DIV1:   pick = pre_tick[0];
            SEL_DIV2:   pick = pre_tick[1];
            SEL_DIV4:   pick = pre_tick[2];
            SEL_DIV8:   pick = pre_tick[3];
            SEL_DIV32:  pick = pre_tick[PRE_W];
            SEL_EXTPIN: begin
                if (!ext_en_i || pwm3_mode_i) err  = 1'b1;
                else                          pick = ext_strobe;
            end
            SEL_HSOSC:  pick = osc_en_i & osc_tick_i;
            SEL_RSVD:   err  = 1'b1;
            default:    err  = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tick_q <= 1'b0;
        else         tick_q <= pick;
    end

    assign count_tick_o = tick_q;
    assign cfg_err_o    = err;

    p_err_blocks_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(cfg_err_o) |-> !count_tick_o);
    p_osc_off_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(src_sel_i == 3'b110 && !osc_en_i) |-> !count_tick_o);

endmodule

// File: tb/test_cnt_src_sel.sv
module test_cnt_src_sel;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 64;

    typedef struct packed {
        logic [2:0] sel;
        logic       en;
        logic [1:0] edg;
        logic       pwm;
        logic       osc;
        logic [7:0] exp_cnt;
        logic       exp_err;
        logic [3:0] req;
    } vec_t;

    // Pin toggles every 4 cycles and the oscillator strobes every 4 cycles in the background.
    localparam vec_t VEC [0:14] = '{
        '{3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd64, 1'b0, 4'd2},  // R2
        '{3'd1, 1'b0, 2'd0, 1'b0, 1'b0, 8'd32, 1'b0, 4'd1},  // R1
        '{3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 8'd16, 1'b0, 4'd1},  // R1
        '{3'd3, 1'b0, 2'd0, 1'b0, 1'b0, 8'd8,  1'b0, 4'd1},  // R1
        '{3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 8'd2,  1'b0, 4'd1},  // R1
        '{3'd4, 1'b0, 2'd0, 1'b1, 1'b0, 8'd2,  1'b0, 4'd5},  // R5 prescaler in PWM3
        '{3'd5, 1'b1, 2'd0, 1'b0, 1'b0, 8'd8,  1'b0, 4'd3},  // R3 rising
        '{3'd5, 1'b1, 2'd1, 1'b0, 1'b0, 8'd8,  1'b0, 4'd3},  // R3 falling
        '{3'd5, 1'b1, 2'd2, 1'b0, 1'b0, 8'd16, 1'b0, 4'd3},  // R3 both
        '{3'd5, 1'b1, 2'd3, 1'b0, 1'b0, 8'd8,  1'b0, 4'd3},  // R3 reserved
        '{3'd5, 1'b0, 2'd0, 1'b0, 1'b1, 8'd0,  1'b1, 4'd4},  // R4
        '{3'd5, 1'b1, 2'd2, 1'b1, 1'b1, 8'd0,  1'b1, 4'd5},  // R5
        '{3'd7, 1'b1, 2'd2, 1'b0, 1'b1, 8'd0,  1'b1, 4'd6},  // R6
        '{3'd6, 1'b1, 2'd2, 1'b0, 1'b1, 8'd16, 1'b0, 4'd7},  // R7 enabled
        '{3'd6, 1'b1, 2'd2, 1'b0, 1'b0, 8'd0,  1'b0, 4'd7}   // R7 disabled
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       en = 1'b0;
    logic [1:0] edg = 2'd0;
    logic       pwm = 1'b0;
    logic       pin = 1'b0;
    logic       osc_en = 1'b0;
    logic       osc_tk = 1'b0;
    logic       tick;
    logic       err;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    int seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    cnt_src_sel i_cnt_src_sel (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_sel_i   (sel),
        .ext_en_i    (en),
        .edge_sel_i  (edg),
        .pwm3_mode_i (pwm),
        .ext_pin_i   (pin),
        .osc_en_i    (osc_en),
        .osc_tick_i  (osc_tk),
        .count_tick_o(tick),
        .cfg_err_o   (err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // n cycles with background pin/oscillator activity, counting strobes at negedges.
    task automatic run_bg(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen += int'(tick);
            pin    = ((ph / 4) % 2) == 1;
            osc_tk = (ph % 4) == 0;
            ph++;
        end
    endtask

    // n quiet cycles with a fixed pin level, counting strobes.
    task automatic hold(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen += int'(tick);
            pin    = lvl;
            osc_tk = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R9 tick in reset", int'(tick), 0);
        check(err == 1'b0, "R11 err for code 000", int'(err), 0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk
        foreach (VEC[r]) begin
            sel = VEC[r].sel; en = VEC[r].en; edg = VEC[r].edg;
            pwm = VEC[r].pwm; osc_en = VEC[r].osc;
            seen = 0;
            run_bg(8);
            seen = 0;
            run_bg(WIN);
            if (seen != int'(VEC[r].exp_cnt))
                $display("  row %0d (req R%0d)", r, VEC[r].req);
            check(seen == int'(VEC[r].exp_cnt), "R1/R2/R3/R4/R5/R6/R7 table count",
                  seen, int'(VEC[r].exp_cnt));
            check(err == VEC[r].exp_err, "R11 table error flag", int'(err), int'(VEC[r].exp_err));
        end

        // R9: pin high through reset, rising selection, no spurious count
        @(negedge clk);
        rst_n = 1'b0; pin = 1'b1; osc_tk = 1'b0;
        sel = 3'd5; en = 1'b1; edg = 2'd0; pwm = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        seen = 0;
        hold(1'b1, 12);
        check(seen == 0, "R9 no spurious rise after reset", seen, 0);

        // R10: latency of a single rising edge
        hold(1'b0, 6);
        seen = 0;
        @(negedge clk) pin = 1'b1;
        @(negedge clk) check(tick == 1'b0, "R10 not after edge k", int'(tick), 0);
        @(negedge clk) check(tick == 1'b0, "R10 not after edge k+1", int'(tick), 0);
        @(negedge clk) check(tick == 1'b1, "R10 strobe after edge k+2", int'(tick), 1);
        @(negedge clk) check(tick == 1'b0, "R10 single cycle", int'(tick), 0);

        // R8: 3-cycle phases, both edges
        edg = 2'd2;
        hold(1'b1, 6);
        seen = 0;
        for (int p = 0; p < 5; p++) begin
            hold(1'b0, 3);
            hold(1'b1, 3);
        end
        hold(1'b1, 6);
        check(seen == 10, "R8 three-cycle phases counted", seen, 10);

        // R9: pin high through reset, falling selection, exactly one count on drop
        @(negedge clk);
        rst_n = 1'b0; pin = 1'b1; edg = 2'd1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        seen = 0;
        hold(1'b1, 10);
        check(seen == 0, "R9 no spurious fall after reset", seen, 0);
        hold(1'b0, 8);
        check(seen == 1, "R9 first real fall counted once", seen, 1);

        // R1: prescaler restarts from reset, divide-by-2 phase
        @(negedge clk);
        rst_n = 1'b0; sel = 3'd1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk) check(tick == 1'b0, "R1 div2 first cycle", int'(tick), 0);
        @(negedge clk) check(tick == 1'b1, "R1 div2 second cycle", int'(tick), 1);
        @(negedge clk) check(tick == 1'b0, "R1 div2 third cycle", int'(tick), 0);
        @(negedge clk) check(tick == 1'b1, "R1 div2 fourth cycle", int'(tick), 1);

        // R11: flag follows select in the same cycle
        sel = 3'd7; #1;
        check(err == 1'b1, "R11 flag rises with code 111", int'(err), 1);
        sel = 3'd6; #1;
        check(err == 1'b0, "R11 flag drops with code 110", int'(err), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule